// File: doc/BRIEF.md
# LIN Response Byte Sequencer

This block runs the response half of a LIN frame once the identifier has been handled. When the header finishes, it samples the node's configured role for that frame: transmit the data (publish), capture the data (subscribe), or stay out of it (ignore). It also works out how many data bytes the response carries and then walks through the data bytes and the closing checksum byte. It trades each byte with a UART-style bit engine over a simple byte handshake.

The byte count comes from one of two sources. In user mode it is the 8-bit length code plus one, which gives 1 to 256 bytes. In identifier mode it is taken from two identifier bits, following the older LIN length rule, and can only be 2, 4 or 8. The checksum byte always comes after the data bytes and is not part of the count.

The block does not serialize bits, generate break or sync, or compute the checksum. It only sequences the bytes and marks which byte is the checksum.

States:
- `S_IDLE`: no frame.
- `S_HDR`: a header is in progress and the block waits for it to complete.
- `S_PUB_DATA` / `S_PUB_CSUM`: publishing the data bytes, then the checksum.
- `S_SUB_DATA` / `S_SUB_CSUM`: receiving the data bytes, then the checksum.

Transitions:
- header start: any state to `S_HDR`.
- header done in `S_HDR`: to the publish data state, the subscribe data state, or `S_IDLE` (for ignore or for the reserved action).
- last data handshake: data state to checksum state.
- checksum handshake: checksum state to `S_IDLE`.

Top module: `lin_resp_seq`

## Requirements
- R1: During and after a synchronous reset (`rst` high), the block is idle. `tx_req`, `rx_take`, `resp_done` and `resp_err` are all 0.
- R2: With `len_mode`=0, the response holds `len_code`+1 data bytes (1 to 256), followed by one checksum byte. A code of 255 gives 256 data bytes with no wrap.
- R3: With `len_mode`=1, the data byte count comes from `frame_id[5:4]`: 00 gives 2, 01 gives 2, 10 gives 4, 11 gives 8. `len_code` is ignored in this mode.
- R4: Publish (`node_act`=01) works as follows:
  - `tx_req` stays high with `tx_csum`=0 and `byte_idx`=i for data byte i, until each byte is acknowledged by `tx_ack`.
  - After the last data byte, one more request is made with `tx_csum`=1 and `byte_idx` equal to the count.
  - `resp_done` pulses for one cycle after the checksum is acknowledged.
- R5: Subscribe (`node_act`=10) works as follows:
  - Each `rx_valid` is accepted as `rx_take` (combinational), and `byte_idx` advances.
  - The byte after the data bytes is flagged `rx_csum`=1.
  - `resp_done` pulses for one cycle after it is accepted.
- R6: Ignore (`node_act`=00) raises `resp_done` in the cycle after header done. No `tx_req` is made and no `rx_take` is given.
- R7: The reserved action (`node_act`=11) pulses `resp_err` in the cycle after header done, gives no `resp_done`, and returns the block to idle.
- R8: A `hdr_start` during a publish or subscribe response abandons it. `resp_err` pulses for one cycle, requests stop, and the block waits for the new header.
- R9: `rx_valid` has no effect while publishing, and `tx_ack` has no effect while subscribing.
- R10: `hdr_done` is acted on only after a `hdr_start`. In idle it produces no done, error or request.
- R11: The configuration inputs are sampled at header done. Changes during the response do not alter the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_start | input | 1 | Pulse: a new header has begun |
| hdr_done | input | 1 | Pulse: the header (identifier) has completed |
| node_act | input | 2 | Role: 00 ignore, 01 publish, 10 subscribe, 11 reserved |
| len_mode | input | 1 | 0: length from code, 1: length from identifier |
| len_code | input | 8 | User length code (bytes minus one) |
| frame_id | input | 8 | Received or sent identifier |
| tx_req | output | 1 | A byte is requested from the transmit side |
| tx_csum | output | 1 | The requested byte is the checksum |
| tx_ack | input | 1 | Bit engine takes the requested byte |
| rx_valid | input | 1 | Bit engine presents a received byte |
| rx_take | output | 1 | Received byte is accepted this cycle |
| rx_csum | output | 1 | The next accepted byte is the checksum |
| byte_idx | output | 9 | Index of the current byte within the response |
| resp_done | output | 1 | One-cycle pulse: the response completed |
| resp_err | output | 1 | One-cycle pulse: reserved action or abandoned response |

## Verification
The bench aims at the ends of the length range:
- A one-byte response from code 0. A design that treats the code as the count would send no data before the checksum.
- A 256-byte response from code 255. An 8-bit counter would wrap and end after the checksum of a zero-length frame.

It checks all four identifier codes, including the two that both give 2. A swapped decode would show up as a wrong checksum position.

It also checks the following:
- An abort in mid-response. A design that ignores it would keep requesting bytes.
- Handshakes aimed at the wrong direction. A design that is not gated by role would move `byte_idx`.
- Configuration changes after header done. A design that decodes the length live would stretch or cut the frame.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;

    typedef enum logic [1:0] {
        ACT_IGNORE    = 2'b00,
        ACT_PUBLISH   = 2'b01,
        ACT_SUBSCRIBE = 2'b10,
        ACT_RESERVED  = 2'b11
    } node_act_e;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_HDR      = 3'd1,
        S_PUB_DATA = 3'd2,
        S_PUB_CSUM = 3'd3,
        S_SUB_DATA = 3'd4,
        S_SUB_CSUM = 3'd5
    } resp_state_e;

endpackage

// File: rtl/lin_len_calc.sv
// Data byte count of the response, checksum excluded.
module lin_len_calc #(
    parameter int LEN_W   = 8,
    parameter int ID_W    = 8,
    parameter int ID_LSB  = 4,
    localparam int CNT_W  = LEN_W + 1
) (
    input  logic             len_mode,
    input  logic [LEN_W-1:0] len_code,
    input  logic [ID_W-1:0]  frame_id,
    output logic [CNT_W-1:0] len_bytes
);

    logic [1:0] id_sel;

    assign id_sel = frame_id[ID_LSB +: 2];

    always_comb begin
        if (!len_mode) begin
            // widen before adding so code all-ones yields 2**LEN_W
            len_bytes = {1'b0, len_code} + CNT_W'(1);
        end else begin
            unique case (id_sel)
                2'b00, 2'b01: len_bytes = CNT_W'(2);
                2'b10:        len_bytes = CNT_W'(4);
                default:      len_bytes = CNT_W'(8);
            endcase
        end
    end

endmodule

// File: rtl/lin_byte_ctr.sv
// Position of the current byte within the response.
module lin_byte_ctr #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/lin_resp_seq.sv
module lin_resp_seq
    import lin_resp_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int ID_W   = 8,
    parameter int ID_LSB = 4,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_start,
    input  logic             hdr_done,
    input  logic [1:0]       node_act,
    input  logic             len_mode,
    input  logic [LEN_W-1:0] len_code,
    input  logic [ID_W-1:0]  frame_id,
    output logic             tx_req,
    output logic             tx_csum,
    input  logic             tx_ack,
    input  logic             rx_valid,
    output logic             rx_take,
    output logic             rx_csum,
    output logic [CNT_W-1:0] byte_idx,
    output logic             resp_done,
    output logic             resp_err
);

    resp_state_e      state, state_nxt;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] len_new;
    logic [CNT_W-1:0] ctr;
    logic             ctr_clr, ctr_inc, load_len;
    logic             done_nxt, err_nxt;
    logic             busy;
    node_act_e        act;

    assign act  = node_act_e'(node_act);
    assign busy = (state == S_PUB_DATA) || (state == S_PUB_CSUM) ||
                  (state == S_SUB_DATA) || (state == S_SUB_CSUM);

    lin_len_calc #(
        .LEN_W (LEN_W),
        .ID_W  (ID_W),
        .ID_LSB(ID_LSB)
    ) len_i (
        .len_mode (len_mode),
        .len_code (len_code),
        .frame_id (frame_id),
        .len_bytes(len_new)
    );

    lin_byte_ctr #(
        .W(CNT_W)
    ) ctr_i (
        .clk(clk),
        .rst(rst),
        .clr(ctr_clr),
        .inc(ctr_inc),
        .cnt(ctr)
    );

    // next state and pulse decisions
    always_comb begin
        state_nxt = state;
        done_nxt  = 1'b0;
        err_nxt   = 1'b0;
        load_len  = 1'b0;
        ctr_clr   = 1'b0;
        ctr_inc   = 1'b0;
        if (hdr_start) begin
            state_nxt = S_HDR;
            ctr_clr   = 1'b1;
            err_nxt   = busy;
        end else begin
            unique case (state)
                S_IDLE: begin
                    state_nxt = S_IDLE;
                end
                S_HDR: begin
                    if (hdr_done) begin
                        load_len = 1'b1;
                        ctr_clr  = 1'b1;
                        unique case (act)
                            ACT_PUBLISH:   state_nxt = S_PUB_DATA;
                            ACT_SUBSCRIBE: state_nxt = S_SUB_DATA;
                            ACT_IGNORE: begin
                                state_nxt = S_IDLE;
                                done_nxt  = 1'b1;
                            end
                            default: begin
                                state_nxt = S_IDLE;
                                err_nxt   = 1'b1;
                            end
                        endcase
                    end
                end
                S_PUB_DATA: begin
                    if (tx_ack) begin
                        ctr_inc = 1'b1;
                        if (ctr == count_q - CNT_W'(1)) state_nxt = S_PUB_CSUM;
                    end
                end
                S_PUB_CSUM: begin
                    if (tx_ack) begin
                        state_nxt = S_IDLE;
                        done_nxt  = 1'b1;
                    end
                end
                S_SUB_DATA: begin
                    if (rx_valid) begin
                        ctr_inc = 1'b1;
                        if (ctr == count_q - CNT_W'(1)) state_nxt = S_SUB_CSUM;
                    end
                end
                S_SUB_CSUM: begin
                    if (rx_valid) begin
                        state_nxt = S_IDLE;
                        done_nxt  = 1'b1;
                    end
                end
                default: state_nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            count_q   <= '0;
            resp_done <= 1'b0;
            resp_err  <= 1'b0;
        end else begin
            state     <= state_nxt;
            resp_done <= done_nxt;
            resp_err  <= err_nxt;
            if (load_len) count_q <= len_new;
        end
    end

    // outputs
    always_comb begin
        tx_req  = 1'b0;
        tx_csum = 1'b0;
        rx_take = 1'b0;
        rx_csum = 1'b0;
        unique case (state)
            S_PUB_DATA: tx_req = 1'b1;
            S_PUB_CSUM: begin
                tx_req  = 1'b1;
                tx_csum = 1'b1;
            end
            S_SUB_DATA: rx_take = rx_valid;
            S_SUB_CSUM: begin
                rx_take = rx_valid;
                rx_csum = 1'b1;
            end
            default: begin
                tx_req = 1'b0;
            end
        endcase
    end

    assign byte_idx = ctr;

    // R4, R5: one direction at a time
    a_r4_one_direction: assert property (@(posedge clk) disable iff (rst)
        !(tx_req && rx_take));

    // R4: checksum handshake completes the frame
    a_r4_csum_then_done: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_csum && tx_ack && !hdr_start) |=> resp_done);

    // R5: received checksum completes the frame
    a_r5_rx_csum_then_done: assert property (@(posedge clk) disable iff (rst)
        (rx_take && rx_csum && !hdr_start) |=> resp_done);

    // R6: ignore finishes right after the header
    a_r6_ignore_done: assert property (@(posedge clk) disable iff (rst)
        (state == S_HDR && hdr_done && !hdr_start && node_act == 2'b00)
        |=> (resp_done && !tx_req));

    // R7: reserved role flags and never completes
    a_r7_reserved_err: assert property (@(posedge clk) disable iff (rst)
        (state == S_HDR && hdr_done && !hdr_start && node_act == 2'b11)
        |=> (resp_err && !resp_done));

    // R8: abort returns to header wait
    a_r8_abort: assert property (@(posedge clk) disable iff (rst)
        (busy && hdr_start) |=> (resp_err && state == S_HDR && !tx_req));

    // R2: position never runs past the data count
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (count_q != '0 && byte_idx <= count_q));

endmodule

// File: tb/lin_resp_seq_tb_top.sv
module lin_resp_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hdr_start = 1'b0, hdr_done = 1'b0;
    logic [1:0] node_act = 2'b00;
    logic       len_mode = 1'b0;
    logic [7:0] len_code = 8'd0, frame_id = 8'd0;
    logic       tx_req, tx_csum, tx_ack = 1'b0;
    logic       rx_valid = 1'b0, rx_take, rx_csum;
    logic [8:0] byte_idx;
    logic       resp_done, resp_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_resp_seq dut_i (
        .clk(clk), .rst(rst), .hdr_start(hdr_start), .hdr_done(hdr_done),
        .node_act(node_act), .len_mode(len_mode), .len_code(len_code),
        .frame_id(frame_id), .tx_req(tx_req), .tx_csum(tx_csum),
        .tx_ack(tx_ack), .rx_valid(rx_valid), .rx_take(rx_take),
        .rx_csum(rx_csum), .byte_idx(byte_idx), .resp_done(resp_done),
        .resp_err(resp_err)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // header start, then header done with the given config; returns at negedge after
    task automatic header(input logic [1:0] act, input logic mode,
                          input logic [7:0] code, input logic [7:0] id);
        @(negedge clk);
        hdr_start = 1'b1;
        @(negedge clk);
        hdr_start = 1'b0;
        hdr_done  = 1'b1;
        node_act  = act;
        len_mode  = mode;
        len_code  = code;
        frame_id  = id;
        @(negedge clk);
        hdr_done = 1'b0;
    endtask

    // publish n data bytes + checksum; optionally disturb config after header
    task automatic run_publish(input int n, input string req, input logic disturb);
        int got_data = 0;
        if (disturb) begin
            len_code = 8'd200;
            len_mode = ~len_mode;
            frame_id = ~frame_id;
        end
        for (int i = 0; i <= n; i++) begin
            check(tx_req == 1'b1, req, tx_req, 1);
            check(tx_csum == (i == n), req, tx_csum, (i == n));
            check(byte_idx == 9'(i), req, byte_idx, i);
            if (!tx_csum) got_data++;
            if (i == 0) begin
                rx_valid = 1'b1; #1;
                check(rx_take == 1'b0, "R9 rx during publish", rx_take, 0);
                rx_valid = 1'b0;
            end
            tx_ack = 1'b1;
            @(negedge clk);
            tx_ack = 1'b0;
        end
        check(got_data == n, req, got_data, n);
        check(resp_done == 1'b1 && tx_req == 1'b0, req, resp_done, 1);
        @(negedge clk);
        check(resp_done == 1'b0, req, resp_done, 0);
    endtask

    task automatic run_subscribe(input int n, input string req);
        // stray tx_ack must not advance
        tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
        check(byte_idx == 9'd0, "R9 ack during subscribe", byte_idx, 0);
        for (int i = 0; i <= n; i++) begin
            check(rx_csum == (i == n), req, rx_csum, (i == n));
            check(byte_idx == 9'(i), req, byte_idx, i);
            check(tx_req == 1'b0, req, tx_req, 0);
            rx_valid = 1'b1; #1;
            check(rx_take == 1'b1, req, rx_take, 1);
            @(negedge clk);
            rx_valid = 1'b0;
        end
        check(resp_done == 1'b1, req, resp_done, 1);
        @(negedge clk);
        check(resp_done == 1'b0, req, resp_done, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(!tx_req && !rx_take && !resp_done && !resp_err, "R1 during reset", tx_req, 0);
        rst = 1'b0;
        @(negedge clk);
        rx_valid = 1'b1; #1;
        check(!tx_req && !rx_take && !resp_done && !resp_err, "R1 after reset", rx_take, 0);
        rx_valid = 1'b0;
    endtask

    task automatic t_ignore;
        header(2'b00, 1'b0, 8'd5, 8'h00);
        check(resp_done == 1'b1, "R6 done after header", resp_done, 1);
        check(tx_req == 1'b0, "R6 no request", tx_req, 0);
        rx_valid = 1'b1; #1;
        check(rx_take == 1'b0, "R6 no capture", rx_take, 0);
        @(negedge clk);
        rx_valid = 1'b0;
        check(resp_done == 1'b0, "R6 single pulse", resp_done, 0);
    endtask

    task automatic t_reserved;
        header(2'b11, 1'b0, 8'd3, 8'h00);
        check(resp_err == 1'b1, "R7 error pulse", resp_err, 1);
        check(resp_done == 1'b0, "R7 no done", resp_done, 0);
        check(tx_req == 1'b0, "R7 idle", tx_req, 0);
        @(negedge clk);
        check(resp_err == 1'b0, "R7 single pulse", resp_err, 0);
    endtask

    task automatic t_abort;
        header(2'b01, 1'b0, 8'd9, 8'h00);
        repeat (3) begin
            tx_ack = 1'b1;
            @(negedge clk);
        end
        tx_ack = 1'b0;
        check(byte_idx == 9'd3, "R8 progressed", byte_idx, 3);
        hdr_start = 1'b1;
        @(negedge clk);
        hdr_start = 1'b0;
        check(resp_err == 1'b1, "R8 abort error", resp_err, 1);
        check(tx_req == 1'b0, "R8 requests stop", tx_req, 0);
        check(byte_idx == 9'd0, "R8 index cleared", byte_idx, 0);
        @(negedge clk);
        check(resp_err == 1'b0 && tx_req == 1'b0, "R8 waits header", resp_err, 0);
        hdr_done = 1'b1;
        node_act = 2'b00;
        @(negedge clk);
        hdr_done = 1'b0;
        check(resp_done == 1'b1, "R8 new header honoured", resp_done, 1);
    endtask

    task automatic t_stray_done;
        @(negedge clk);
        hdr_done = 1'b1;
        node_act = 2'b00;
        @(negedge clk);
        hdr_done = 1'b0;
        check(!resp_done && !resp_err && !tx_req, "R10 hdr_done in idle", resp_done, 0);
        hdr_done = 1'b1;
        node_act = 2'b01;
        @(negedge clk);
        hdr_done = 1'b0;
        check(tx_req == 1'b0, "R10 no publish from idle", tx_req, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-R actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        header(2'b01, 1'b0, 8'd0, 8'h00);  run_publish(1,   "R2 code0 R4", 1'b0);
        header(2'b01, 1'b0, 8'd4, 8'h00);  run_publish(5,   "R4 publish5", 1'b0);
        header(2'b01, 1'b0, 8'd255, 8'h00); run_publish(256, "R2 code255", 1'b0);
        header(2'b01, 1'b0, 8'd2, 8'h30);  run_publish(3,   "R11 config frozen", 1'b1);
        header(2'b10, 1'b1, 8'd99, 8'h00); run_subscribe(2, "R3 id00 R5");
        header(2'b10, 1'b1, 8'd99, 8'h10); run_subscribe(2, "R3 id01");
        header(2'b10, 1'b1, 8'd99, 8'h20); run_subscribe(4, "R3 id10");
        header(2'b10, 1'b1, 8'd0, 8'hF0);  run_subscribe(8, "R3 id11");
        header(2'b10, 1'b0, 8'd6, 8'h00);  run_subscribe(7, "R5 subscribe7");
        header(2'b01, 1'b1, 8'd0, 8'h20);  run_publish(4,   "R3 publish id10", 1'b0);
        t_ignore();
        t_reserved();
        t_abort();
        t_stray_done();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule